// File: doc/BRIEF.md
# Indirect Jump Target Predictor

This block guesses where an indirect jump will land: jump-table dispatch, computed gotos and calls through a function pointer or method table. Such a jump can have many destinations, so the block does not use the jump address alone to find a stored guess. It folds the jump address into a table index and XORs that with a global register. The register holds the low bits of the most recent resolved destinations. Because of this, one jump can keep a separate destination for each recent path that led to it.

Fetch presents a jump address and, one cycle later, receives a hit flag, the predicted destination and the history value used. The pipeline carries that history with the jump. When the jump executes, the back end returns the jump address, the carried history, the prediction it was given and the real destination. The block writes the real destination into the entry that the carried history selects, and shifts the destination bits into the global register. It also raises a one-cycle miss pulse when the guess was absent or wrong. Table entries can be shared by unrelated jumps, so this check is always needed.

Top module: `itp_predictor`

## Requirements
- R1: After reset every table entry is empty, the global history is zero, and `pr_rsp`, `pr_hit`, `pr_tgt`, `pr_hist` and `rs_miss` are all zero.
- R2: A lookup (`lk_req` high at a clock edge) sets `pr_rsp` high on the next cycle. In that cycle `pr_hist` equals the global history as it stood at the lookup edge.
- R3: The entry index is the global history XOR the XOR-fold of the address. The address is rotated right by 2 bits, then split into 8-bit slices that are XORed together. For an address below 1024 the index is `pc[9:2] ^ history`. Two addresses that fold to the same index share one entry. When `pr_hit` is low, `pr_tgt` is zero.
- R4: A resolution (`rs_req` high) stores `rs_tgt` into the entry indexed by `rs_pc` and `rs_hist`, and marks that entry valid. A later lookup of the same address under the same history returns `pr_hit` high with that target.
- R5: Each resolution shifts the global history left by 2 and places `rs_tgt[3:2]` in bits 1:0. Without a resolution the history keeps its value.
- R6: One address resolved under two different histories keeps two independent targets. A lookup returns the one that matches the current history.
- R7: `rs_miss` is high for exactly the cycle after a resolution in which `rs_pred_hit` was low or `rs_pred_tgt` differed from `rs_tgt`. It is low after a resolution whose prediction matched, and low in any cycle that follows no resolution.
- R8: A jump whose index collides with another jump's entry receives that other jump's target as its prediction. Resolving it with its own target then gives a miss pulse and overwrites the shared entry.
- R9: When a lookup and a resolution hit the same entry at the same edge, the lookup returns the entry's content and the history from before that edge.
- R10: In a cycle after an edge with no lookup, `pr_rsp` and `pr_hit` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_req | input | 1 | Lookup request |
| lk_pc | input | ADDR_W | Address of the jump being fetched |
| pr_rsp | output | 1 | Lookup answer valid (one cycle after request) |
| pr_hit | output | 1 | Selected entry held a target |
| pr_tgt | output | ADDR_W | Predicted target, zero when no hit |
| pr_hist | output | HIST_W | History used for the lookup; to be carried with the jump |
| rs_req | input | 1 | Resolution of an executed indirect jump |
| rs_pc | input | ADDR_W | Address of the resolved jump |
| rs_hist | input | HIST_W | History carried from its lookup |
| rs_pred_hit | input | 1 | Hit flag it was given at lookup |
| rs_pred_tgt | input | ADDR_W | Target it was given at lookup |
| rs_tgt | input | ADDR_W | Actual target |
| rs_miss | output | 1 | One-cycle pulse: prediction absent or wrong |

## Verification
The hardest case to reach from the ports is a lookup whose global history equals a chosen value. Every resolution shifts its own target bits into the history, so the history cannot be written directly. The bench therefore steers it with four filler resolutions whose target bits spell out the wanted history, and a reference model tracks the entries those fillers write. With this, the bench can hit one address under two chosen contexts, force a collision between two addresses, and line up a same-edge read and write to one entry.

// File: rtl/itp_pkg.sv
package itp_pkg;
    localparam int unsigned ITP_ADDR_W  = 32;
    localparam int unsigned ITP_HIST_W  = 8;
    localparam int unsigned ITP_ALIGN_W = 2;
    localparam int unsigned ITP_SHIFT_W = 2;
endpackage

// File: rtl/itp_hash.sv
module itp_hash #(
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned IDX_W   = 8,
    parameter int unsigned ALIGN_W = 2
) (
    input  logic [ADDR_W-1:0] pc,
    input  logic [IDX_W-1:0]  hist,
    output logic [IDX_W-1:0]  idx
);
    localparam int unsigned NCH   = (ADDR_W + IDX_W - 1) / IDX_W;
    localparam int unsigned PAD_W = NCH * IDX_W;

    logic [PAD_W-1:0]          rot;
    logic [NCH:0][IDX_W-1:0]   acc;

    assign rot    = PAD_W'({pc[ALIGN_W-1:0], pc[ADDR_W-1:ALIGN_W]});
    assign acc[0] = hist;

    for (genvar g = 0; g < NCH; g++) begin : g_fold
        assign acc[g+1] = acc[g] ^ rot[g*IDX_W +: IDX_W];
    end

    assign idx = acc[NCH];
endmodule

// File: rtl/itp_history.sv
module itp_history #(
    parameter int unsigned HIST_W  = 8,
    parameter int unsigned SHIFT_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               upd,
    input  logic [SHIFT_W-1:0] bits_in,
    output logic [HIST_W-1:0]  hist_o
);
    logic [HIST_W-1:0] hist_d, hist_q;

    always_comb begin
        hist_d = hist_q;
        if (upd) begin
            hist_d = {hist_q[HIST_W-SHIFT_W-1:0], bits_in};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hist_q <= '0;
        else        hist_q <= hist_d;
    end

    assign hist_o = hist_q;
endmodule

// File: rtl/itp_table.sv
module itp_table #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned IDX_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_vld,
    output logic [ADDR_W-1:0] rd_tgt,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [ADDR_W-1:0] wr_tgt
);
    localparam int unsigned DEPTH = 1 << IDX_W;

    logic [DEPTH-1:0]  vld_d, vld_q;
    logic [ADDR_W-1:0] tgt_q [DEPTH];

    always_comb begin
        vld_d = vld_q;
        if (wr_en) begin
            vld_d[wr_idx] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vld_q <= '0;
        else        vld_q <= vld_d;
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tgt_q[wr_idx] <= wr_tgt;
        end
    end

    assign rd_vld = vld_q[rd_idx];
    assign rd_tgt = tgt_q[rd_idx];
endmodule

// File: rtl/itp_predictor.sv
module itp_predictor #(
    parameter int unsigned ADDR_W  = itp_pkg::ITP_ADDR_W,
    parameter int unsigned HIST_W  = itp_pkg::ITP_HIST_W,
    parameter int unsigned ALIGN_W = itp_pkg::ITP_ALIGN_W,
    parameter int unsigned SHIFT_W = itp_pkg::ITP_SHIFT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_req,
    input  logic [ADDR_W-1:0] lk_pc,
    output logic              pr_rsp,
    output logic              pr_hit,
    output logic [ADDR_W-1:0] pr_tgt,
    output logic [HIST_W-1:0] pr_hist,
    input  logic              rs_req,
    input  logic [ADDR_W-1:0] rs_pc,
    input  logic [HIST_W-1:0] rs_hist,
    input  logic              rs_pred_hit,
    input  logic [ADDR_W-1:0] rs_pred_tgt,
    input  logic [ADDR_W-1:0] rs_tgt,
    output logic              rs_miss
);
    localparam int unsigned IDX_W = HIST_W;

    typedef struct packed {
        logic              rsp;
        logic              hit;
        logic [ADDR_W-1:0] tgt;
        logic [HIST_W-1:0] hist;
        logic              miss;
    } out_t;

    out_t st_d, st_q;

    logic [HIST_W-1:0] hist_now;
    logic [IDX_W-1:0]  lk_idx, rs_idx;
    logic              rd_vld;
    logic [ADDR_W-1:0] rd_tgt;

    itp_hash #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .ALIGN_W(ALIGN_W)) u_hash_lk (
        .pc(lk_pc), .hist(hist_now), .idx(lk_idx)
    );

    itp_hash #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .ALIGN_W(ALIGN_W)) u_hash_rs (
        .pc(rs_pc), .hist(rs_hist), .idx(rs_idx)
    );

    itp_table #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_tab (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(lk_idx), .rd_vld(rd_vld), .rd_tgt(rd_tgt),
        .wr_en(rs_req), .wr_idx(rs_idx), .wr_tgt(rs_tgt)
    );

    itp_history #(.HIST_W(HIST_W), .SHIFT_W(SHIFT_W)) u_hist (
        .clk(clk), .rst_n(rst_n), .upd(rs_req),
        .bits_in(rs_tgt[ALIGN_W +: SHIFT_W]), .hist_o(hist_now)
    );

    always_comb begin
        st_d      = '0;
        st_d.rsp  = lk_req;
        st_d.hit  = lk_req && rd_vld;
        st_d.tgt  = (lk_req && rd_vld) ? rd_tgt : '0;
        st_d.hist = lk_req ? hist_now : '0;
        st_d.miss = rs_req && (!rs_pred_hit || (rs_pred_tgt != rs_tgt));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pr_rsp  = st_q.rsp;
    assign pr_hit  = st_q.hit;
    assign pr_tgt  = st_q.tgt;
    assign pr_hist = st_q.hist;
    assign rs_miss = st_q.miss;
endmodule

// File: rtl/itp_checker.sv
module itp_checker #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned HIST_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lk_req,
    input logic              rs_req,
    input logic              rs_pred_hit,
    input logic [ADDR_W-1:0] rs_pred_tgt,
    input logic [ADDR_W-1:0] rs_tgt,
    input logic              pr_rsp,
    input logic              pr_hit,
    input logic [ADDR_W-1:0] pr_tgt,
    input logic              rs_miss,
    input logic [HIST_W-1:0] hist
);
    AST_RSP_AFTER_LOOKUP: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> pr_rsp);                                              // R2
    AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |=> (!pr_rsp && !pr_hit));                               // R10
    AST_ZERO_TGT_ON_NOHIT: assert property (@(posedge clk) disable iff (!rst_n)
        !pr_hit |-> (pr_tgt == '0));                                     // R3
    AST_MISS_ON_NOPRED: assert property (@(posedge clk) disable iff (!rst_n)
        (rs_req && !rs_pred_hit) |=> rs_miss);                           // R7
    AST_NO_MISS_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (rs_req && rs_pred_hit && (rs_pred_tgt == rs_tgt)) |=> !rs_miss); // R7
    AST_MISS_NEEDS_RESOLVE: assert property (@(posedge clk) disable iff (!rst_n)
        !rs_req |=> !rs_miss);                                           // R7
    AST_HIST_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !rs_req |=> $stable(hist));                                      // R5
endmodule

bind itp_predictor itp_checker #(.ADDR_W(ADDR_W), .HIST_W(HIST_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .rs_req(rs_req),
    .rs_pred_hit(rs_pred_hit), .rs_pred_tgt(rs_pred_tgt), .rs_tgt(rs_tgt),
    .pr_rsp(pr_rsp), .pr_hit(pr_hit), .pr_tgt(pr_tgt), .rs_miss(rs_miss),
    .hist(hist_now)
);

// File: tb/itp_predictor_test.sv
module itp_predictor_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_req = 1'b0;
    logic [31:0] lk_pc = '0;
    logic        pr_rsp, pr_hit, rs_miss;
    logic [31:0] pr_tgt;
    logic [7:0]  pr_hist;
    logic        rs_req = 1'b0;
    logic [31:0] rs_pc = '0;
    logic [7:0]  rs_hist = '0;
    logic        rs_pred_hit = 1'b0;
    logic [31:0] rs_pred_tgt = '0;
    logic [31:0] rs_tgt = '0;

    int n_chk = 0;
    int n_bad = 0;

    logic [31:0] m_tgt [256];
    logic        m_vld [256];
    logic [7:0]  m_hist;

    always #5 clk = ~clk;

    itp_predictor uut (
        .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_pc(lk_pc),
        .pr_rsp(pr_rsp), .pr_hit(pr_hit), .pr_tgt(pr_tgt), .pr_hist(pr_hist),
        .rs_req(rs_req), .rs_pc(rs_pc), .rs_hist(rs_hist),
        .rs_pred_hit(rs_pred_hit), .rs_pred_tgt(rs_pred_tgt), .rs_tgt(rs_tgt),
        .rs_miss(rs_miss)
    );

    function automatic logic [7:0] fidx(input logic [31:0] pc, input logic [7:0] h);
        logic [31:0] r;
        r = {pc[1:0], pc[31:2]};
        return r[7:0] ^ r[15:8] ^ r[23:16] ^ r[31:24] ^ h;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic model_write(input logic [31:0] pc, input logic [7:0] h, input logic [31:0] t);
        m_tgt[fidx(pc, h)] = t;
        m_vld[fidx(pc, h)] = 1'b1;
        m_hist = {m_hist[5:0], t[3:2]};
    endtask

    task automatic lookup(input logic [31:0] pc, output logic hit, output logic [31:0] tgt,
                          output logic [7:0] h);
        logic [7:0] i;
        logic [7:0] eh;
        @(negedge clk);
        lk_req = 1'b1; lk_pc = pc;
        eh = m_hist; i = fidx(pc, m_hist);
        @(negedge clk);
        lk_req = 1'b0;
        chk("R2 rsp", {31'b0, pr_rsp}, 32'd1);
        chk("R2 hist", {24'b0, pr_hist}, {24'b0, eh});
        chk("R4 hit", {31'b0, pr_hit}, {31'b0, m_vld[i]});
        chk("R3 tgt", pr_tgt, m_vld[i] ? m_tgt[i] : 32'h0);
        hit = pr_hit; tgt = pr_tgt; h = pr_hist;
    endtask

    task automatic resolve(input logic [31:0] pc, input logic [7:0] h, input logic ph,
                           input logic [31:0] pt, input logic [31:0] t);
        @(negedge clk);
        rs_req = 1'b1; rs_pc = pc; rs_hist = h;
        rs_pred_hit = ph; rs_pred_tgt = pt; rs_tgt = t;
        @(negedge clk);
        rs_req = 1'b0;
        chk("R7 miss", {31'b0, rs_miss}, {31'b0, (!ph || pt != t)});
        model_write(pc, h, t);
        @(negedge clk);
        chk("R7 pulse ends", {31'b0, rs_miss}, 32'd0);
    endtask

    task automatic set_hist(input logic [7:0] h);
        resolve(32'h0000_0f00, m_hist, 1'b0, 32'h0, 32'h0000_8000 | {28'b0, h[7:6], 2'b0});
        resolve(32'h0000_0f00, m_hist, 1'b0, 32'h0, 32'h0000_8000 | {28'b0, h[5:4], 2'b0});
        resolve(32'h0000_0f00, m_hist, 1'b0, 32'h0, 32'h0000_8000 | {28'b0, h[3:2], 2'b0});
        resolve(32'h0000_0f00, m_hist, 1'b0, 32'h0, 32'h0000_8000 | {28'b0, h[1:0], 2'b0});
        chk("R5 history steered", {24'b0, m_hist}, {24'b0, h});
    endtask

    task automatic t_reset();
        logic hit; logic [31:0] t; logic [7:0] h;
        chk("R1 rsp", {31'b0, pr_rsp}, 32'd0);
        chk("R1 hit", {31'b0, pr_hit}, 32'd0);
        chk("R1 tgt", pr_tgt, 32'd0);
        chk("R1 hist", {24'b0, pr_hist}, 32'd0);
        chk("R1 miss", {31'b0, rs_miss}, 32'd0);
        lookup(32'h0000_0040, hit, t, h);
        chk("R1 empty entry", {31'b0, hit}, 32'd0);
    endtask

    task automatic t_first_resolve();
        logic hit; logic [31:0] t; logic [7:0] h;
        resolve(32'h0000_0100, 8'h00, 1'b0, 32'h0, 32'h0000_200c);
        lookup(32'h0000_0200, hit, t, h);
        chk("R5 shifted history", {24'b0, h}, 32'h03);
    endtask

    task automatic t_learn_hit();
        logic hit; logic [31:0] t; logic [7:0] h;
        resolve(32'h0000_0120, 8'h5a, 1'b0, 32'h0, 32'h0001_2340);
        set_hist(8'h5a);
        lookup(32'h0000_0120, hit, t, h);
        chk("R4 learned target", t, 32'h0001_2340);
        resolve(32'h0000_0120, h, hit, t, 32'h0001_2340);
    endtask

    task automatic t_contexts();
        logic hit; logic [31:0] t; logic [7:0] h;
        resolve(32'h0000_0080, 8'h11, 1'b0, 32'h0, 32'h0000_a000);
        resolve(32'h0000_0080, 8'hc4, 1'b0, 32'h0, 32'h0000_b004);
        set_hist(8'h11);
        lookup(32'h0000_0080, hit, t, h);
        chk("R6 context A", t, 32'h0000_a000);
        set_hist(8'hc4);
        lookup(32'h0000_0080, hit, t, h);
        chk("R6 context B", t, 32'h0000_b004);
    endtask

    task automatic t_alias();
        logic hit; logic [31:0] t; logic [7:0] h;
        resolve(32'h0000_0400, 8'h00, 1'b0, 32'h0, 32'h0000_c000);
        set_hist(8'h00);
        lookup(32'h0000_0004, hit, t, h);
        chk("R3 folded upper bit shares entry", t, 32'h0000_c000);
        resolve(32'h0000_0004, h, hit, t, 32'h0000_d008);
        set_hist(8'h00);
        lookup(32'h0000_0400, hit, t, h);
        chk("R8 shared entry overwritten", t, 32'h0000_d008);
        resolve(32'h0000_0400, h, hit, t, 32'h0000_c000);
    endtask

    task automatic t_same_cycle();
        logic [7:0] i; logic [7:0] eh; logic ev; logic [31:0] et;
        set_hist(8'h33);
        eh = m_hist; i = fidx(32'h0000_0300, m_hist);
        ev = m_vld[i]; et = ev ? m_tgt[i] : 32'h0;
        @(negedge clk);
        lk_req = 1'b1; lk_pc = 32'h0000_0300;
        rs_req = 1'b1; rs_pc = 32'h0000_0300; rs_hist = eh;
        rs_pred_hit = 1'b0; rs_pred_tgt = 32'h0; rs_tgt = 32'h0000_e00c;
        @(negedge clk);
        lk_req = 1'b0; rs_req = 1'b0;
        chk("R9 old hit", {31'b0, pr_hit}, {31'b0, ev});
        chk("R9 old tgt", pr_tgt, et);
        chk("R9 old hist", {24'b0, pr_hist}, {24'b0, eh});
        chk("R7 miss no pred", {31'b0, rs_miss}, 32'd1);
        model_write(32'h0000_0300, eh, 32'h0000_e00c);
    endtask

    task automatic t_idle();
        @(negedge clk);
        @(negedge clk);
        chk("R10 rsp idle", {31'b0, pr_rsp}, 32'd0);
        chk("R10 hit idle", {31'b0, pr_hit}, 32'd0);
    endtask

    task automatic t_bulk();
        logic [31:0] lf = 32'h1ace_b00c;
        logic hit; logic [31:0] t; logic [7:0] h; logic [31:0] pc; logic [31:0] nt;
        for (int k = 0; k < 200; k++) begin
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            pc = {26'b0, lf[3:0], 2'b0};
            nt = 32'h0004_0000 | {26'b0, lf[9:8], 4'b0} | {28'b0, lf[5:4], 2'b0};
            lookup(pc, hit, t, h);
            resolve(pc, h, hit, t, nt);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int k = 0; k < 256; k++) begin
            m_vld[k] = 1'b0;
            m_tgt[k] = '0;
        end
        m_hist = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_first_resolve();
        t_learn_hit();
        t_contexts();
        t_alias();
        t_same_cycle();
        t_idle();
        t_bulk();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule